// File: doc/BRIEF.md
# Mixed-Mode GPIO Data Register

This block is the data register of a fourteen-pin general-purpose port, seen by software as one 16-bit word at a single decoded address. The six upper pins are backed by writable output latches. When a pin's function control marks it as a general input, its read bit shows the pin level instead of the latch. When the pin is a general output, the latch drives that pin's bit of the output-drive vector. The eight lower pins are input only. Their read bits are a live, synchronized view of the pins, and writes to them are thrown away. The two top bits are reserved.

Two reset kinds reach the block. Power-on reset clears the output latches. Manual reset leaves them untouched. Standby and sleep also leave them untouched. All pin inputs pass through a two-flop synchronizer, so a read shows a pin change two clock edges after the change. Read data is combinational from the address, the latches and the synchronized pins.

Top module: `gpio_split_dreg`

## Requirements
- R1: Read bits 15 and 14 are always 0. The values written to them change nothing.
- R2: A write strobe (`wr_en` high for one cycle with `addr` equal to the register address) loads `wdata[13:8]` into the six latches at that clock edge. A strobe at any other address changes no latch.
- R3: While `por_n` is low, the latches are cleared to 0 at once, without waiting for a clock edge. This clear wins over a concurrent manual reset.
- R4: While `mrst_n` is low, or `standby` is high, or `sleep` is high, the latches keep their contents and write strobes are ignored.
- R5: For an upper pin whose `pin_cfg` bit is 1 (general input), read bit 8+i returns the synchronized level of pin 8+i.
- R6: For an upper pin whose `pin_cfg` bit is 0 (general output), read bit 8+i returns latch i and `pin_out[i]` drives latch i. `pin_out[i]` is 0 while the pin is an input.
- R7: Written values on `wdata[7:0]` are discarded. They never show up in read data and never reach any output.
- R8: Read bits 7..0 equal `pin_in[7:0]` as sampled two clock edges earlier. This holds through manual reset, standby and sleep.
- R9: When `addr` is not the register address, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low |
| standby | input | 1 | Standby mode indication |
| sleep | input | 1 | Sleep mode indication |
| addr | input | ADDR_W | Register bus address |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 16 | Write data word |
| rdata | output | 16 | Read data word, combinational |
| pin_cfg | input | 6 | Per upper pin: 1 general input, 0 general output |
| pin_in | input | 14 | Pin levels, pins 13..0 |
| pin_out | output | 6 | Output drive for pins 13..8 |

## Verification
The bench writes words with bits set in the reserved and input-only fields. A design that stored those bits would read back a nonzero top or low byte. It mixes input and output configurations across the upper pins in one word, which exposes a swapped select or a drive that still leaks onto `pin_out` for input pins. It strobes writes during manual reset, standby and sleep, where a design that merely gated the reset would take the new value. It holds both resets low together, where a design with the priorities reversed would fail to clear. It also samples the low byte one edge and two edges after a pin change, so a design with the wrong synchronizer depth shows the new value too early or too late.

// File: rtl/gpio_split_dreg.sv
module gpio_split_dreg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24,
  parameter int HI_N = 6,
  parameter int LO_N = 8,
  parameter int RSV_N = 2,
  parameter int SYNC_N = 2
) (
  input  logic                      clk,
  input  logic                      por_n,
  input  logic                      mrst_n,
  input  logic                      standby,
  input  logic                      sleep,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr_en,
  input  logic [HI_N+LO_N+RSV_N-1:0] wdata,
  output logic [HI_N+LO_N+RSV_N-1:0] rdata,
  input  logic [HI_N-1:0]           pin_cfg,
  input  logic [HI_N+LO_N-1:0]      pin_in,
  output logic [HI_N-1:0]           pin_out
);
  localparam int PIN_N = HI_N + LO_N;
  localparam int DW    = PIN_N + RSV_N;

  logic             sel, wr_ok;
  logic [HI_N-1:0]  lat_q, hi_rd;
  logic [PIN_N-1:0] sync_q [SYNC_N];
  logic [PIN_N-1:0] pin_s;
  logic [DW-1:0]    word;

  assign sel   = (addr == REG_ADDR);
  assign wr_ok = wr_en && sel && mrst_n && !standby && !sleep;

  always_ff @(posedge clk) begin
    sync_q[0] <= pin_in;
    for (int k = 1; k < SYNC_N; k++) sync_q[k] <= sync_q[k-1];
  end
  assign pin_s = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     lat_q <= '0;
    else if (wr_ok) lat_q <= wdata[PIN_N-1:LO_N];
  end

  for (genvar i = 0; i < HI_N; i++) begin : g_hi
    assign hi_rd[i]   = pin_cfg[i] ? pin_s[LO_N+i] : lat_q[i];
    assign pin_out[i] = pin_cfg[i] ? 1'b0 : lat_q[i];
  end

  assign word  = {{RSV_N{1'b0}}, hi_rd, pin_s[LO_N-1:0]};
  assign rdata = sel ? word : '0;

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R1
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    rdata[DW-1:PIN_N] == '0);

  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_ok |=> lat_q == HI_N'($past(wdata) >> LO_N));

  // R3
  por_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(por_n) |-> lat_q == '0);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n || standby || sleep) |=> $stable(lat_q));

  if (SYNC_N == 2) begin : g_lat_chk
    // R8
    lo_track_chk: assert property (@(posedge clk) disable iff (!por_n)
      (warm_q == 2'd3 && sel) |-> rdata[LO_N-1:0] == $past(pin_in[LO_N-1:0], 2));
  end
endmodule

// File: tb/gpio_split_dreg_tb.sv
module gpio_split_dreg_tb;
  localparam int CLK_NS = 10;
  localparam logic [7:0] RA = 8'h24;

  // {cfg, pins, wdata, exp_rdata, exp_pout}
  localparam logic [57:0] VEC [6] = '{
    {6'h00, 14'h0000, 16'hFFFF, 16'h3F00, 6'h3F},
    {6'h3F, 14'h2AA5, 16'h0000, 16'h2AA5, 6'h00},
    {6'h00, 14'h3FFF, 16'hC000, 16'h00FF, 6'h00},
    {6'h0F, 14'h155A, 16'h3C3C, 16'h355A, 6'h30},
    {6'h30, 14'h0F0F, 16'h15FF, 16'h050F, 6'h05},
    {6'h2A, 14'h3F00, 16'h1500, 16'h3F00, 6'h15}
  };

  logic clk = 0, por_n = 0, mrst_n = 1, standby = 0, sleep = 0, wr_en = 0;
  logic [7:0]  addr = RA;
  logic [15:0] wdata = '0, rdata;
  logic [5:0]  pin_cfg = '0, pin_out;
  logic [13:0] pin_in = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_split_dreg u_dut (.clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby),
    .sleep(sleep), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pin_cfg(pin_cfg), .pin_in(pin_in), .pin_out(pin_out));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_case(input string req, input int kind);
    @(negedge clk);
    pin_in[7:0] = 8'h3C + 8'(kind);
    if (kind == 0) mrst_n = 0; else if (kind == 1) standby = 1; else sleep = 1;
    wr_en = 1; wdata = 16'h2A00;
    @(negedge clk); wr_en = 0;
    chk(req, {10'h0, pin_out}, 16'h0015);
    @(negedge clk);
    chk({req, " R8 lo byte"}, {8'h0, rdata[7:0]}, {8'h0, 8'h3C + 8'(kind)});
    mrst_n = 1; standby = 0; sleep = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    #1;
    chk("R3 reset rdata", rdata, 16'h0000);
    chk("R3 reset pin_out", {10'h0, pin_out}, 16'h0000);

    // R1 R2 R5 R6 R7 vectors
    foreach (VEC[v]) begin
      @(negedge clk);
      pin_cfg = VEC[v][57:52]; pin_in = VEC[v][51:38]; wdata = VEC[v][37:22]; wr_en = 1;
      @(negedge clk); wr_en = 0;
      @(negedge clk);
      chk($sformatf("R1/R2/R5/R6/R7 vec%0d rdata", v), rdata, VEC[v][21:6]);
      chk($sformatf("R6 vec%0d pin_out", v), {10'h0, pin_out}, {10'h0, VEC[v][5:0]});
    end

    // R9 / R2 wrong address
    @(negedge clk); addr = 8'h25; pin_cfg = '0; #1;
    chk("R9 unselected rdata", rdata, 16'h0000);
    wr_en = 1; wdata = 16'h3F00;
    @(negedge clk); wr_en = 0; addr = RA; #1;
    chk("R2 other address ignored", {10'h0, pin_out}, 16'h0015);

    hold_case("R4 manual reset", 0);
    hold_case("R4 standby", 1);
    hold_case("R4 sleep", 2);

    @(negedge clk); wr_en = 1; wdata = 16'h2A00;
    @(negedge clk); wr_en = 0; #1;
    chk("R2 write after low power", {10'h0, pin_out}, 16'h002A);

    // R8 latency
    @(negedge clk); pin_in[7:0] = 8'h81;
    @(negedge clk); chk("R8 one edge old", {8'h0, rdata[7:0]}, 16'h003E);
    @(negedge clk); chk("R8 two edges new", {8'h0, rdata[7:0]}, 16'h0081);

    // R3 priority over manual reset
    @(negedge clk); mrst_n = 0; por_n = 0; #1;
    chk("R3 async clear", {10'h0, pin_out}, 16'h0000);
    @(negedge clk); por_n = 1; mrst_n = 1; #1;
    chk("R3 clear kept", {10'h0, pin_out}, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule